// File: doc/BRIEF.md
# Interrupt Mask and Output Port Unit

This block is the shared, chip-level piece of a two-channel serial controller. It collects each channel's transmit-ready and receive-ready event lines into an interrupt status word and qualifies that word with a mask. It also drives an active-low interrupt request line to the host.

The same unit holds a general-purpose output port. A host never writes that port as a whole. It raises bits through one address and lowers bits through another, so two software contexts can share the port without a read-modify-write race. A mode register picks, pin by pin, whether an output pin follows its port bit or carries the matching interrupt status bit. Raw input pin levels can be read back through a further address.

Register access is a 4-bit address with a single-cycle write strobe. The read data is combinational on the address.

Top module: `imou_top`

## Requirements
- R1: After reset the mask, the output port register and the pin-mode register are all zero. irq_no is high, every output pin is high, and no interrupt is raised for any pattern of event lines until the mask is written.
- R2: Reading address 0x5 returns the live status word. Bit 4n is tx_rdy_i[n] and bit 4n+1 is rx_rdy_i[n]. Bits 4n+2 and 4n+3 read as zero. Status follows the event lines in the same cycle and is not latched.
- R3: Writing address 0x5 loads the interrupt mask from the write data. Reading address 0x5 afterwards still returns the status, not the mask.
- R4: irq_no is a registered output. After a clock edge it is low if (status AND mask) was nonzero just before that edge, and high otherwise. Its value therefore changes one clock edge after the status or the mask changes.
- R5: Writing address 0xE sets every output port bit written as 1. Bits written as 0 are left unchanged.
- R6: Writing address 0xF clears every output port bit written as 1. Bits written as 0 are left unchanged.
- R7: While its mode bit is 0, output pin i is driven with the complement of output port bit i.
- R8: Writing address 0xD loads the pin-mode register. A pin whose mode bit is 1 is driven with the complement of status bit (i mod 4·NUM_CH). Writing 0 returns every pin to port control.
- R9: Reading address 0x4 returns the input pin levels unmodified, with no inversion.
- R10: Reads of any address other than 0x4 and 0x5 return zero. Writes to any address other than 0x5, 0xD, 0xE and 0xF change neither the mask, the port register, the mode, the pins nor irq_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| tx_rdy_i | input | NUM_CH | Per-channel transmit-ready event |
| rx_rdy_i | input | NUM_CH | Per-channel receive-ready event |
| in_pins_i | input | IN_W | Raw input pin levels |
| out_pins_o | output | OUT_W | Output pins |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block at its default parameters: two channels and 8-bit data, input and output widths. At these values the status word fills the data bus exactly. Channel 1's events land in the upper nibble, and every output pin has a distinct status bit to carry in function mode. These widths put the group packing of both channels, mixed pin modes and the whole port within reach of short directed patterns.

// File: rtl/imou_pkg.sv
package imou_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_INPORT = 4'h4;
  localparam logic [ADDR_W-1:0] A_IRQ    = 4'h5;
  localparam logic [ADDR_W-1:0] A_OMODE  = 4'hD;
  localparam logic [ADDR_W-1:0] A_OSET   = 4'hE;
  localparam logic [ADDR_W-1:0] A_OCLR   = 4'hF;
  localparam int GRP_W   = 4;   // status bits per channel
  localparam int TX_OFS  = 0;
  localparam int RX_OFS  = 1;
endpackage

// File: rtl/imou_irq.sv
module imou_irq
  import imou_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int SW    = GRP_W * NUM_CH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NUM_CH-1:0] tx_rdy_i,
  input  logic [NUM_CH-1:0] rx_rdy_i,
  input  logic          mask_we_i,
  input  logic [SW-1:0] mask_d_i,
  output logic [SW-1:0] status_o,
  output logic          irq_no
);
  logic [SW-1:0] mask_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_grp
    assign status_o[GRP_W*c+TX_OFS] = tx_rdy_i[c];
    assign status_o[GRP_W*c+RX_OFS] = rx_rdy_i[c];
    assign status_o[GRP_W*c+3:GRP_W*c+2] = 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~|(status_o & mask_q);
  end

  p_mask_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
  p_irq_assert_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_o & mask_q)) |=> !irq_no);
  p_irq_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_o & mask_q)) |=> irq_no);
endmodule

// File: rtl/imou_oport.sv
module imou_oport #(
  parameter int OUT_W = 8,
  parameter int SW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic             mode_we_i,
  input  logic [OUT_W-1:0] wdata_i,
  input  logic [SW-1:0]    status_i,
  output logic [OUT_W-1:0] pins_o
);
  logic [OUT_W-1:0] op_q, mode_q, set_v, clr_v;

  assign set_v = set_we_i ? wdata_i : '0;
  assign clr_v = clr_we_i ? wdata_i : '0;

  // clear has priority over set on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= '0;
    else         op_q <= (op_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= wdata_i;
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_pin
    assign pins_o[i] = mode_q[i] ? ~status_i[i % SW] : ~op_q[i];
  end

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((op_q & $past(wdata_i)) == $past(wdata_i)));
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((op_q & $past(wdata_i)) == '0));
  p_op_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(op_q));
  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_q));
endmodule

// File: rtl/imou_top.sv
module imou_top
  import imou_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8,
  parameter int IN_W   = 8,
  parameter int OUT_W  = 8,
  localparam int SW    = GRP_W * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] tx_rdy_i,
  input  logic [NUM_CH-1:0] rx_rdy_i,
  input  logic [IN_W-1:0]   in_pins_i,
  output logic [OUT_W-1:0]  out_pins_o,
  output logic              irq_no
);
  logic [SW-1:0] status;
  logic mask_we, set_we, clr_we, mode_we;

  assign mask_we = wr_i && (addr_i == A_IRQ);
  assign set_we  = wr_i && (addr_i == A_OSET);
  assign clr_we  = wr_i && (addr_i == A_OCLR);
  assign mode_we = wr_i && (addr_i == A_OMODE);

  imou_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i, .rst_ni,
    .tx_rdy_i, .rx_rdy_i,
    .mask_we_i(mask_we),
    .mask_d_i(wdata_i[SW-1:0]),
    .status_o(status),
    .irq_no
  );

  imou_oport #(.OUT_W(OUT_W), .SW(SW)) u_oport (
    .clk_i, .rst_ni,
    .set_we_i(set_we),
    .clr_we_i(clr_we),
    .mode_we_i(mode_we),
    .wdata_i(wdata_i[OUT_W-1:0]),
    .status_i(status),
    .pins_o(out_pins_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_INPORT: rdata_o[IN_W-1:0] = in_pins_i;
      A_IRQ:    rdata_o[SW-1:0]   = status;
      default:  ;
    endcase
  end
endmodule

// File: tb/imou_top_tb.sv
module imou_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0, rdata, in_pins = 8'hA5, pins;
  logic [1:0] tx = '0, rx = '0;
  logic irq_n;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  imou_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_rdy_i(tx), .rx_rdy_i(rx), .in_pins_i(in_pins),
    .out_pins_o(pins), .irq_no(irq_n)
  );

  typedef struct packed {
    logic [3:0] tag; logic we; logic [3:0] ad; logic [7:0] wd;
    logic [1:0] tx; logic [1:0] rx; logic [7:0] rd; logic irq; logic [7:0] pins;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  1'b0, 4'h5, 8'h00, 2'b01, 2'b00, 8'h01, 1'b1, 8'hFF}, // R2 tx0
    '{4'd2,  1'b0, 4'h5, 8'h00, 2'b10, 2'b11, 8'h32, 1'b1, 8'hFF}, // R2 ch1 group
    '{4'd3,  1'b1, 4'h5, 8'h02, 2'b00, 2'b00, 8'h00, 1'b1, 8'hFF}, // R3 mask rx0
    '{4'd4,  1'b0, 4'h5, 8'h00, 2'b00, 2'b01, 8'h02, 1'b0, 8'hFF}, // R4 raised
    '{4'd4,  1'b0, 4'h5, 8'h00, 2'b11, 2'b00, 8'h11, 1'b1, 8'hFF}, // R4 masked off
    '{4'd5,  1'b1, 4'hE, 8'h81, 2'b00, 2'b00, 8'h00, 1'b1, 8'h7E}, // R5
    '{4'd5,  1'b1, 4'hE, 8'h06, 2'b00, 2'b00, 8'h00, 1'b1, 8'h78}, // R5 accumulate
    '{4'd6,  1'b1, 4'hF, 8'h03, 2'b00, 2'b00, 8'h00, 1'b1, 8'h7B}, // R6
    '{4'd6,  1'b1, 4'hF, 8'h00, 2'b00, 2'b00, 8'h00, 1'b1, 8'h7B}, // R6 zero write
    '{4'd8,  1'b1, 4'hD, 8'h0F, 2'b01, 2'b10, 8'h00, 1'b1, 8'h7E}, // R8 mixed
    '{4'd7,  1'b1, 4'hD, 8'h00, 2'b01, 2'b10, 8'h00, 1'b1, 8'h7B}, // R7 back to port
    '{4'd9,  1'b0, 4'h4, 8'h00, 2'b00, 2'b00, 8'hA5, 1'b1, 8'h7B}, // R9
    '{4'd10, 1'b1, 4'h7, 8'hFF, 2'b00, 2'b00, 8'h00, 1'b1, 8'h7B}, // R10
    '{4'd4,  1'b1, 4'h5, 8'h10, 2'b10, 2'b00, 8'h10, 1'b0, 8'h7B}  // R4 tx1
  };

  task automatic chk(input string r, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    addr = 4'h5;
    chk("R1", "pins", pins, 8'hFF);
    chk("R1", "irq", {7'd0, irq_n}, 8'h01);
    chk("R1", "status", rdata, 8'h00);
    rst_n = 1'b1;
    tx = 2'b11; rx = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1", "irq unmasked events", {7'd0, irq_n}, 8'h01);
    tx = '0; rx = '0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = TBL[i].ad; wr = TBL[i].we; wdata = TBL[i].wd;
      tx = TBL[i].tx; rx = TBL[i].rx;
      @(negedge clk);
      wr = 1'b0;
      @(negedge clk);
      chk($sformatf("R%0d", TBL[i].tag), "rdata", rdata, TBL[i].rd);
      chk($sformatf("R%0d", TBL[i].tag), "irq", {7'd0, irq_n}, {7'd0, TBL[i].irq});
      chk($sformatf("R%0d", TBL[i].tag), "pins", pins, TBL[i].pins);
    end

    // R4 one-edge latency on release (mask 0x10, tx1 active)
    tx = 2'b00;
    #1 chk("R4", "irq before edge", {7'd0, irq_n}, 8'h00);
    @(negedge clk);
    chk("R4", "irq after edge", {7'd0, irq_n}, 8'h01);
    tx = 2'b10;
    #1 chk("R4", "irq before raise edge", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    chk("R4", "irq after raise edge", {7'd0, irq_n}, 8'h00);

    // R9 second pattern, no inversion
    in_pins = 8'h5A; addr = 4'h4;
    #1 chk("R9", "inport", rdata, 8'h5A);
    addr = 4'hE;
    #1 chk("R10", "read unused", rdata, 8'h00);

    // R1 mid-run reset clears mask, port and mode
    rst_n = 1'b0;
    #1 chk("R1", "pins in reset", pins, 8'hFF);
    chk("R1", "irq in reset", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    tx = 2'b11; rx = 2'b11;
    repeat (2) @(negedge clk);
    chk("R1", "mask cleared", {7'd0, irq_n}, 8'h01);
    chk("R1", "port cleared", pins, 8'hFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule